// File: doc/BRIEF.md
# Adjustable Time-of-Day Clock

This block keeps a time-of-day value as a 48-bit seconds count and a 32-bit nanoseconds count. It advances the value on every reference clock cycle by a programmable period. The period is held in units of 1/256 ns. A fractional accumulator holds the time within the current second in those same units. It rolls over into the seconds count at a fixed 256,000,000,000 units, and software cannot change that modulo. The nanoseconds output is the accumulator with its eight fractional bits dropped.

Software controls the block through a write-only register port. It sets a base period and can load a new time of day with one command. It can also request a temporary signed trim to the period, which lasts for a programmed number of cycles. Software then polls a done flag to learn that the trim has ended. A registered pre-adder combines the base period and the trim before the accumulator. The result is clamped at zero, so a large negative trim can stall the clock but cannot move the time backwards.

Top module: `rtc_adjustable`

## Requirements
- R1: While `rst_n` is low, `time_sec` and `time_ns` are 0 and `adj_done` is 0. The base period resets to 2048 (8 ns), and no trim is active.
- R2: On each clock edge, the accumulator gains the step that was registered on the previous edge. A base-period write accepted at edge k therefore first moves the time at edge k+2.
- R3: When the accumulator plus the step reaches 256,000,000,000 or more, the accumulator keeps the excess and `time_sec` increments by one on that edge.
- R4: `time_ns` always equals the accumulator value shifted right by 8 bits.
- R5: A trim request with count N > 0 adds the signed trim value to the base period for the step computed on each of the next N edges. After that, the step reverts to the base period alone.
- R6: Writing the count register sets `adj_done` to 0, or to 1 if the count is 0. `adj_done` goes to 1 on the edge where the remaining count drops from 1 to 0, and it stays at 1 until the next count write.
- R7: If base plus active trim is zero or negative, the step is 0 for that cycle. Apart from a load, {`time_sec`,`time_ns`} never decreases.
- R8: If base plus active trim exceeds 2^32-1, the step saturates to 2^32-1.
- R9: A write to the load address replaces the seconds and the accumulator on that same edge. The accumulator gets the staged nanoseconds shifted left by 8, with zero fractional bits. A staged nanoseconds value above 999,999,999 is clamped to 999,999,999.
- R10: Register addresses on `wr_addr`:
  - 0: base period (unsigned, 1/256 ns units)
  - 1: trim (signed two's complement)
  - 2: trim cycle count, which also starts the request
  - 3: staged seconds bits 31:0
  - 4: staged seconds bits 47:32, taken from `wr_data[15:0]`
  - 5: staged nanoseconds
  - 6: load command (data ignored)
  - 7: unmapped; writes to it have no effect

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| time_sec | output | 48 | Seconds count |
| time_ns | output | 32 | Nanoseconds within the second |
| adj_done | output | 1 | Trim request finished |

## Verification
A base period or trim written at edge k reaches the step register at edge k+1 and the time outputs at edge k+2. A load or a count write takes effect at edge k itself. The `adj_done` flag follows the remaining count, so it rises N edges after the request edge. The bench drives inputs on falling edges. Its reference model applies every write at the rising edge, with the same one-cycle step delay. It compares the time outputs and `adj_done` at the following falling edge, where each of these latencies shows up in the cycle where it is due.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int PER_W  = 32;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 32;
  localparam int FRAC_W = 8;
  localparam int ACC_W  = 38;
  localparam int ADDR_W = 3;
  localparam int NS_PAD = NS_W - (ACC_W - FRAC_W);
  localparam logic [ACC_W-1:0] ACC_MOD = ACC_W'(64'd256_000_000_000);
  localparam logic [PER_W-1:0] NS_MAX  = PER_W'(32'd999_999_999);

  typedef enum logic [ADDR_W-1:0] {
    SEL_BASE   = 3'd0,
    SEL_TRIM   = 3'd1,
    SEL_COUNT  = 3'd2,
    SEL_SEC_LO = 3'd3,
    SEL_SEC_HI = 3'd4,
    SEL_NS     = 3'd5,
    SEL_LOAD   = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic             wrap;
    logic [ACC_W-1:0] acc;
  } acc_res_t;

  // Base plus optional signed trim, clamped to [0, 2^PER_W-1].
  function automatic logic [PER_W-1:0] trim_step(input logic [PER_W-1:0] base,
                                                 input logic [PER_W-1:0] trim,
                                                 input logic use_trim);
    logic [PER_W+1:0] sum;
    sum = {2'b00, base} + (use_trim ? {{2{trim[PER_W-1]}}, trim} : '0);
    if (sum[PER_W+1] || sum == '0) return '0;
    else if (sum[PER_W])           return '1;
    else                           return sum[PER_W-1:0];
  endfunction

  // One accumulator step with rollover at the fixed modulo.
  function automatic acc_res_t acc_advance(input logic [ACC_W-1:0] acc,
                                           input logic [PER_W-1:0] step);
    acc_res_t r;
    logic [ACC_W:0] t;
    t = {1'b0, acc} + {{(ACC_W+1-PER_W){1'b0}}, step};
    if (t >= {1'b0, ACC_MOD}) begin
      r.wrap = 1'b1;
      r.acc  = ACC_W'(t - {1'b0, ACC_MOD});
    end else begin
      r.wrap = 1'b0;
      r.acc  = t[ACC_W-1:0];
    end
    return r;
  endfunction

  // Staged nanoseconds to accumulator units, clamped below one second.
  function automatic logic [ACC_W-1:0] ns_to_acc(input logic [PER_W-1:0] ns);
    logic [ACC_W-1:0] v;
    v = ACC_W'((ns > NS_MAX) ? NS_MAX : ns);
    return v << FRAC_W;
  endfunction
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter logic [PER_W-1:0] RST_PERIOD = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PER_W-1:0]  wr_data,
  output logic [PER_W-1:0]  base_q,
  output logic [PER_W-1:0]  trim_q,
  output logic              trim_active,
  output logic              adj_done,
  output logic [SEC_W-1:0]  stage_sec,
  output logic [PER_W-1:0]  stage_ns,
  output logic              load_cmd
);
  logic [PER_W-1:0] left_q;
  logic count_wr;

  assign count_wr    = wr_en && (wr_addr == SEL_COUNT);
  assign load_cmd    = wr_en && (wr_addr == SEL_LOAD);
  assign trim_active = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= RST_PERIOD;
      trim_q    <= '0;
      stage_sec <= '0;
      stage_ns  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        SEL_BASE:   base_q <= wr_data;
        SEL_TRIM:   trim_q <= wr_data;
        SEL_SEC_LO: stage_sec[PER_W-1:0] <= wr_data;
        SEL_SEC_HI: stage_sec[SEC_W-1:PER_W] <= wr_data[SEC_W-PER_W-1:0];
        SEL_NS:     stage_ns <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      adj_done <= 1'b0;
    end else if (count_wr) begin
      left_q   <= wr_data;
      adj_done <= (wr_data == '0);
    end else if (trim_active) begin
      left_q <= left_q - 1'b1;
      if (left_q == PER_W'(1)) adj_done <= 1'b1;
    end
  end

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == PER_W'(1) && !count_wr) |=> adj_done);
  p_request_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_wr && wr_data != '0) |=> (!adj_done && trim_active));
endmodule

// File: rtl/rtc_preadd.sv
module rtc_preadd
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] base_q,
  input  logic [PER_W-1:0] trim_q,
  input  logic             trim_active,
  output logic [PER_W-1:0] step_q
);
  logic [PER_W+1:0] raw_sum;
  logic sum_nonpos, sum_over;

  assign raw_sum    = {2'b00, base_q} + (trim_active ? {{2{trim_q[PER_W-1]}}, trim_q} : '0);
  assign sum_nonpos = raw_sum[PER_W+1] || (raw_sum == '0);
  assign sum_over   = !raw_sum[PER_W+1] && raw_sum[PER_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= trim_step(base_q, trim_q, trim_active);
  end

  p_clamp_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sum_nonpos |=> (step_q == '0));
  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sum_over |=> (&step_q));
endmodule

// File: rtl/rtc_accum.sv
module rtc_accum
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] step_q,
  input  logic             load_cmd,
  input  logic [SEC_W-1:0] stage_sec,
  input  logic [PER_W-1:0] stage_ns,
  output logic [SEC_W-1:0] sec_q,
  output logic [ACC_W-1:0] acc_q
);
  acc_res_t nxt;
  logic wrap_evt;

  assign nxt      = acc_advance(acc_q, step_q);
  assign wrap_evt = nxt.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      acc_q <= '0;
    end else if (load_cmd) begin
      sec_q <= stage_sec;
      acc_q <= ns_to_acc(stage_ns);
    end else begin
      acc_q <= nxt.acc;
      if (wrap_evt) sec_q <= sec_q + 1'b1;
    end
  end

  p_acc_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < ACC_MOD);
  p_wrap_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !load_cmd) |=> (sec_q == $past(sec_q) + 1'b1));
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_evt && !load_cmd) |=> (acc_q == $past(acc_q) + ACC_W'($past(step_q))));
  p_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cmd |=> ({sec_q, acc_q} >= $past({sec_q, acc_q})));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_cmd |=> (sec_q == $past(stage_sec) && acc_q[FRAC_W-1:0] == '0));
endmodule

// File: rtl/rtc_adjustable.sv
module rtc_adjustable
  import rtc_pkg::*;
#(
  parameter logic [PER_W-1:0] RST_PERIOD = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PER_W-1:0]  wr_data,
  output logic [SEC_W-1:0]  time_sec,
  output logic [NS_W-1:0]   time_ns,
  output logic              adj_done
);
  logic [PER_W-1:0] base_q, trim_q, stage_ns, step_q;
  logic [SEC_W-1:0] stage_sec;
  logic [ACC_W-1:0] acc_q;
  logic trim_active, load_cmd;

  rtc_regs #(.RST_PERIOD(RST_PERIOD)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base_q(base_q), .trim_q(trim_q), .trim_active(trim_active), .adj_done(adj_done),
    .stage_sec(stage_sec), .stage_ns(stage_ns), .load_cmd(load_cmd)
  );

  rtc_preadd i_preadd (
    .clk(clk), .rst_n(rst_n), .base_q(base_q), .trim_q(trim_q),
    .trim_active(trim_active), .step_q(step_q)
  );

  rtc_accum i_accum (
    .clk(clk), .rst_n(rst_n), .step_q(step_q), .load_cmd(load_cmd),
    .stage_sec(stage_sec), .stage_ns(stage_ns), .sec_q(time_sec), .acc_q(acc_q)
  );

  assign time_ns = {{NS_PAD{1'b0}}, acc_q[ACC_W-1:FRAC_W]};

  p_ns_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    time_ns <= NS_W'(32'd999_999_999));
endmodule

// File: tb/test_rtc_adjustable.sv
module test_rtc_adjustable;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [47:0] time_sec;
  logic [31:0] time_ns;
  logic        adj_done;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  localparam longint MODV = 64'd256000000000;

  // reference model state
  longint m_base = 2048, m_trim = 0, m_left = 0, m_step = 0;
  longint m_acc = 0, m_sec = 0, m_ssec = 0, m_sns = 0;
  bit     m_done = 0, m_loaded = 0;
  logic [79:0] prev_t = '0;
  bit     have_prev = 0;

  always #10 clk = ~clk;

  rtc_adjustable i_rtc_adjustable (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .time_sec(time_sec), .time_ns(time_ns), .adj_done(adj_done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s): actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  always @(posedge clk) begin
    longint s, t;
    if (!rst_n) begin
      m_base = 2048; m_trim = 0; m_left = 0; m_done = 0; m_step = 0;
      m_acc = 0; m_sec = 0; m_ssec = 0; m_sns = 0; m_loaded = 0;
    end else begin
      s = m_base + ((m_left != 0) ? m_trim : 0);
      if (s <= 0) s = 0;
      else if (s > 64'hFFFFFFFF) s = 64'hFFFFFFFF;
      m_loaded = wr_en && (wr_addr == 3'd6);
      if (m_loaded) begin
        m_acc = ((m_sns > 999999999) ? 999999999 : m_sns) * 256;
        m_sec = m_ssec;
      end else begin
        t = m_acc + m_step;
        if (t >= MODV) begin t = t - MODV; m_sec = m_sec + 1; end
        m_acc = t;
      end
      m_step = s;
      if (wr_en && wr_addr == 3'd2) begin
        m_left = longint'(wr_data); m_done = (wr_data == 0);
      end else if (m_left != 0) begin
        if (m_left == 1) m_done = 1;
        m_left = m_left - 1;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_base = longint'(wr_data);
          3'd1: m_trim = longint'($signed(wr_data));
          3'd3: m_ssec = (m_ssec & 64'hFFFF_0000_0000) | longint'(wr_data);
          3'd4: m_ssec = (m_ssec & 64'h0000_FFFF_FFFF) | (longint'(wr_data[15:0]) << 32);
          3'd5: m_sns  = longint'(wr_data);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model (R3 seconds, R4 nanoseconds, R6 done)
  always @(negedge clk) begin
    logic [79:0] now;
    chk("R3 time_sec", longint'(time_sec), m_sec);
    chk("R4 time_ns", longint'(time_ns), m_acc >>> 8);
    chk("R6 adj_done", longint'(adj_done), longint'(m_done));
    now = {time_sec, time_ns};
    if (rst_n && have_prev && !m_loaded)
      chk("R7 monotonic", longint'(now >= prev_t), 1);
    prev_t = now;
    have_prev = rst_n;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (%s): actual=timeout expected=finish", phase);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(2);
    phase = "R1";
    chk("R1 reset sec", longint'(time_sec), 0);
    chk("R1 reset ns", longint'(time_ns), 0);
    chk("R1 reset done", longint'(adj_done), 0);
    rst_n = 1'b1;
    idle(20);

    phase = "R2";                       // 10.5 ns base period
    wr(3'd0, 32'h0000_0A80);
    idle(20);

    phase = "R9";                       // load near a second boundary
    wr(3'd3, 32'h0000_0005);
    wr(3'd4, 32'h0000_0012);
    wr(3'd5, 32'd999_999_900);
    wr(3'd6, 32'h0);
    chk("R9 loaded ns", longint'(time_ns), 999999900);
    chk("R9 loaded sec", longint'(time_sec), 64'h12_0000_0005);

    phase = "R3";                       // rolls into seconds within ~10 cycles
    idle(20);
    chk("R3 sec advanced", longint'(time_sec), 64'h12_0000_0006);

    phase = "R9";                       // clamp of oversized nanoseconds
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0);
    chk("R9 clamped ns", longint'(time_ns), 999999999);
    idle(5);

    phase = "R5";                       // positive then negative trim
    wr(3'd1, 32'd256);
    wr(3'd2, 32'd10);
    chk("R6 cleared", longint'(adj_done), 0);
    idle(15);
    chk("R6 done set", longint'(adj_done), 1);
    wr(3'd1, -32'sd16);
    wr(3'd2, 32'd5);
    idle(10);

    phase = "R6";                       // zero count finishes at once
    wr(3'd2, 32'd0);
    chk("R6 zero count", longint'(adj_done), 1);

    phase = "R7";                       // trim drives sum negative: time stalls
    wr(3'd0, 32'd100);
    wr(3'd1, -32'sd65536);
    wr(3'd2, 32'd8);
    idle(2);
    begin
      logic [31:0] held;
      held = time_ns;
      idle(3);
      chk("R7 stalled", longint'(time_ns), longint'(held));
    end
    idle(10);

    phase = "R8";                       // saturated step
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h7FFF_FFFF);
    wr(3'd2, 32'd70);
    idle(80);

    phase = "R10";                      // unmapped address has no effect
    wr(3'd0, 32'd2048);
    wr(3'd1, 32'd0);
    idle(3);
    wr(3'd7, 32'hFFFF_FFFF);
    idle(10);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule